// File: doc/BRIEF.md
# DMA Channel Allocator and Enable Control

This block keeps the per-channel run state of a multi-channel DMA engine and tells software which channel it can take next. One status word combines the number of the lowest idle channel with a bitmap of every channel that still counts as enabled, so a single read is enough to pick a free channel. Each channel also has a control word holding a pause bit, a two-bit priority, source and destination increment bits and a burst-size exponent. These fields go straight out to the data path.

A stop is a request followed by polling. When software writes 0 to a channel's enable bit, the channel's run output drops at once. The enable bit itself, and the bitmap bit in the status word, stay at 1 until the data path reports that the channel is idle and that no burst it started is still open. The data path is modelled by three inputs per channel: a busy level, a burst-start pulse and a burst-done pulse.

Top module: `dmaalloc_top`

## Requirements
- R1: After reset every channel is disabled and idle. The status word at offset 0x0070 reads 0x00000000, every control word reads 0 and `ch_run` is all zero.
- R2: The status word holds, in bits 4:0, the number of the lowest channel whose enable bit reads 0. Bit 16+n is channel n's enable bit. All other bits read 0.
- R3: When all 16 channels read enabled, status bits 4:0 hold 16, a number no channel has.
- R4: A write of 1 to enable is read back in the next cycle. The status word changes in that same cycle.
- R5: After a write of 0 to enable, the enable bit and its status bit keep reading 1 while the channel's `ch_busy` is high. They clear on the first clock edge at which busy is low, no burst is outstanding and no burst starts.
- R6: A write of 0 to enable on a channel that is already idle clears the bit in the next cycle.
- R7: `ch_run[n]` is 1 exactly when channel n's last written enable is 1 and its pause bit is 0. It drops in the cycle after an enable-0 write, even while the enable bit still reads 1.
- R8: Control word fields are: bit 0 enable, bit 1 pause, bits 3:2 priority (0 highest, 3 lowest), bit 6 source increment, bit 7 destination increment, bits 10:8 burst-size exponent. They read back as written and drive `ch_prio`, `ch_src_inc`, `ch_dst_inc` and `ch_burst_log`. All other bits read 0.
- R9: Channel n's control word sits at 0x1000 + 0x100*n, so address bits 11:8 select the channel. Other addresses read 0 and writes to them change nothing.
- R10: A `burst_start` pulse opens one outstanding burst and a `burst_done` pulse closes one. A channel being stopped stays enabled until its count returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| ch_busy | input | 16 | Per-channel data path busy level |
| burst_start | input | 16 | Per-channel pulse: a burst was issued |
| burst_done | input | 16 | Per-channel pulse: a burst completed |
| ch_run | output | 16 | Per-channel permission to issue new bursts |
| ch_prio | output | 32 | Two-bit priority per channel, channel n at bits 2n+1:2n |
| ch_src_inc | output | 16 | Source address increment select per channel |
| ch_dst_inc | output | 16 | Destination address increment select per channel |
| ch_burst_log | output | 48 | Burst-size exponent per channel, channel n at bits 3n+2:3n |

## Verification
The hardest state to reach is a channel that software has disabled while it still reads enabled. The stimulus first starts a burst and raises busy on that channel, then writes enable 0. It then releases the two hold conditions one at a time and checks the status word before and after each release. That is how the bench confirms that the busy level and the outstanding count each delay the stop on their own. Free-index corner cases are reached by enabling every channel and then freeing one in the middle of the range.

// File: rtl/dmaalloc_pkg.sv
package dmaalloc_pkg;

  localparam logic [15:0] STATUS_OFS = 16'h0070;
  localparam logic [3:0]  CH_WINDOW  = 4'h1;

  typedef struct packed {
    logic [2:0] burst_log;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] prio;
    logic       pause;
  } chcfg_t;

  function automatic chcfg_t cfg_from_word(input logic [31:0] w);
    chcfg_t c;
    c.pause     = w[1];
    c.prio      = w[3:2];
    c.src_inc   = w[6];
    c.dst_inc   = w[7];
    c.burst_log = w[10:8];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input chcfg_t c, input logic en);
    logic [31:0] w;
    w        = '0;
    w[0]     = en;
    w[1]     = c.pause;
    w[3:2]   = c.prio;
    w[6]     = c.src_inc;
    w[7]     = c.dst_inc;
    w[10:8]  = c.burst_log;
    return w;
  endfunction

endpackage

// File: rtl/dmaalloc_rst_sync.sv
module dmaalloc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dmaalloc_chan.sv
module dmaalloc_chan
  import dmaalloc_pkg::*;
#(
  parameter int MAX_OUT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        burst_start,
  input  logic        burst_done,
  output logic        en_stat,
  output logic        en_req,
  output logic        run,
  output chcfg_t      cfg
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);

  chcfg_t           cfg_q, cfg_n;
  logic             en_req_q, en_req_n;
  logic             en_stat_q, en_stat_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_ld, stat_ld, quiet;

  // next-state
  always_comb begin
    cfg_n    = cfg_from_word(wdata);
    en_req_n = wr ? wdata[0] : en_req_q;
    cnt_n    = cnt_q;
    unique case ({burst_start, burst_done})
      2'b10:   cnt_n = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
      2'b01:   cnt_n = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
    cnt_ld    = burst_start ^ burst_done;
    quiet     = !busy && (cnt_q == '0) && !burst_start;
    en_stat_n = en_req_n | (en_stat_q & ~quiet);
    stat_ld   = (en_stat_n != en_stat_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      en_req_q  <= 1'b0;
      en_stat_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (wr) begin
        cfg_q    <= cfg_n;
        en_req_q <= en_req_n;
      end
      if (cnt_ld)  cnt_q     <= cnt_n;
      if (stat_ld) en_stat_q <= en_stat_n;
    end
  end

  assign en_stat = en_stat_q;
  assign en_req  = en_req_q;
  assign run     = en_req_q & ~cfg_q.pause;
  assign cfg     = cfg_q;
endmodule

// File: rtl/dmaalloc_free_enc.sv
module dmaalloc_free_enc #(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input  logic [NUM_CH-1:0] en_stat,
  output logic [IDX_W-1:0]  free_idx
);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NUM_CH);

  always_comb begin
    free_idx = NONE_IDX;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (!en_stat[i]) free_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dmaalloc_regif.sv
module dmaalloc_regif
  import dmaalloc_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input  logic              reg_wr,
  input  logic [15:0]       reg_addr,
  input  logic [NUM_CH-1:0] en_stat,
  input  logic [IDX_W-1:0]  free_idx,
  input  chcfg_t            cfg [NUM_CH],
  output logic [NUM_CH-1:0] wr_ch,
  output logic [31:0]       rdata
);
  localparam logic [4:0] NUM_CH_L = 5'(NUM_CH);

  logic [3:0] ch_sel;
  logic       in_window, ch_hit, status_hit;

  always_comb begin
    ch_sel     = reg_addr[11:8];
    in_window  = (reg_addr[15:12] == CH_WINDOW) && (reg_addr[7:0] == 8'h00);
    ch_hit     = in_window && ({1'b0, ch_sel} < NUM_CH_L);
    status_hit = (reg_addr == STATUS_OFS);
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wr_ch[i] = reg_wr && ch_hit && (ch_sel == 4'(i));
    end
  end

  always_comb begin
    rdata = '0;
    if (status_hit) begin
      rdata[IDX_W-1:0]   = free_idx;
      rdata[16 +: NUM_CH] = en_stat;
    end else if (ch_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_sel == 4'(i)) rdata = cfg_to_word(cfg[i], en_stat[i]);
      end
    end
  end
endmodule

// File: rtl/dmaalloc_top.sv
module dmaalloc_top
  import dmaalloc_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int MAX_OUT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [15:0]           reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NUM_CH-1:0]     ch_busy,
  input  logic [NUM_CH-1:0]     burst_start,
  input  logic [NUM_CH-1:0]     burst_done,
  output logic [NUM_CH-1:0]     ch_run,
  output logic [2*NUM_CH-1:0]   ch_prio,
  output logic [NUM_CH-1:0]     ch_src_inc,
  output logic [NUM_CH-1:0]     ch_dst_inc,
  output logic [3*NUM_CH-1:0]   ch_burst_log
);
  localparam int IDX_W = $clog2(NUM_CH + 1);

  logic              rst_sync_n;
  logic [NUM_CH-1:0] en_stat, en_req, wr_ch;
  logic [IDX_W-1:0]  free_idx;
  chcfg_t            cfg [NUM_CH];

  dmaalloc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dmaalloc_chan #(.MAX_OUT(MAX_OUT)) u_chan (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .wr          (wr_ch[g]),
      .wdata       (reg_wdata),
      .busy        (ch_busy[g]),
      .burst_start (burst_start[g]),
      .burst_done  (burst_done[g]),
      .en_stat     (en_stat[g]),
      .en_req      (en_req[g]),
      .run         (ch_run[g]),
      .cfg         (cfg[g])
    );
    assign ch_prio[2*g +: 2]      = cfg[g].prio;
    assign ch_src_inc[g]          = cfg[g].src_inc;
    assign ch_dst_inc[g]          = cfg[g].dst_inc;
    assign ch_burst_log[3*g +: 3] = cfg[g].burst_log;
  end

  dmaalloc_free_enc #(.NUM_CH(NUM_CH)) u_enc (
    .en_stat  (en_stat),
    .free_idx (free_idx)
  );

  dmaalloc_regif #(.NUM_CH(NUM_CH)) u_regif (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .en_stat  (en_stat),
    .free_idx (free_idx),
    .cfg      (cfg),
    .wr_ch    (wr_ch),
    .rdata    (reg_rdata)
  );
endmodule

// File: rtl/dmaalloc_chk.sv
module dmaalloc_chk #(
  parameter int NUM_CH = 16,
  localparam int IDX_W = $clog2(NUM_CH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] en_stat,
  input logic [NUM_CH-1:0] en_req,
  input logic [IDX_W-1:0]  free_idx,
  input logic [NUM_CH-1:0] ch_busy,
  input logic [NUM_CH-1:0] ch_run
);
  localparam logic [IDX_W-1:0] NONE_IDX = IDX_W'(NUM_CH);

  logic [NUM_CH-1:0] below, at_idx;
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      below[i]  = (IDX_W'(i) < free_idx);
      at_idx[i] = (IDX_W'(i) == free_idx);
    end
  end

  // R2
  lowest_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_idx != NONE_IDX) |-> (((en_stat & at_idx) == '0) && ((en_stat & below) == below)));

  // R3
  none_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_idx == NONE_IDX) |-> (&en_stat));

  // R4
  req_implies_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req & ~en_stat) == '0);

  // R5
  no_clear_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~en_stat) & $past(en_stat) & $past(ch_busy)) == '0);

  // R7
  run_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run & ~en_req) == '0);
endmodule

bind dmaalloc_top dmaalloc_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_stat  (en_stat),
  .en_req   (en_req),
  .free_idx (free_idx),
  .ch_busy  (ch_busy),
  .ch_run   (ch_run)
);

// File: tb/dmaalloc_top_bench.sv
`timescale 1ns/1ps
module dmaalloc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [15:0] ch_busy, burst_start, burst_done;
  logic [15:0] ch_run, ch_src_inc, ch_dst_inc;
  logic [31:0] ch_prio;
  logic [47:0] ch_burst_log;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dmaalloc_top u_dmaalloc_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_busy(ch_busy),
    .burst_start(burst_start), .burst_done(burst_done), .ch_run(ch_run),
    .ch_prio(ch_prio), .ch_src_inc(ch_src_inc), .ch_dst_inc(ch_dst_inc),
    .ch_burst_log(ch_burst_log)
  );

  function automatic logic [15:0] caddr(input int ch);
    return 16'h1000 + 16'(ch) * 16'h0100;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_reset();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    ch_busy = '0; burst_start = '0; burst_done = '0;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(16'h0070, d); check("R1 status", d, 32'h0);
    rd(caddr(0), d); check("R1 ctrl0", d, 32'h0);
    check("R1 run", {16'h0, ch_run}, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    do_reset();
    wr(caddr(5), 32'hFFFF_F800 | 32'h5FB);
    rd(caddr(5), d); check("R8 readback", d, 32'h5CB);
    check("R8 prio port", {30'h0, ch_prio[11:10]}, 32'h2);
    check("R8 inc ports", {30'h0, ch_src_inc[5], ch_dst_inc[5]}, 32'h3);
    check("R8 burst port", {29'h0, ch_burst_log[17:15]}, 32'h5);
    check("R7 paused run", {31'h0, ch_run[5]}, 32'h0);
    wr(caddr(5), 32'h5C9);
    check("R7 unpaused run", {16'h0, ch_run}, 32'h0020);
    rd(16'h0070, d); check("R2 status ch5", d, 32'h0020_0000);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    wr(caddr(0), 32'h1);
    rd(caddr(0), d); check("R4 ctrl0 next cycle", d, 32'h1);
    rd(16'h0070, d); check("R4 status same cycle", d, 32'h0001_0001);
    for (int c = 1; c < 5; c++) wr(caddr(c), 32'h1);
    wr(caddr(6), 32'h1);
    rd(16'h0070, d); check("R2 hole at 5", d, 32'h005F_0005);
    wr(caddr(2), 32'h0);
    rd(caddr(2), d); check("R6 idle stop", d, 32'h0);
    rd(16'h0070, d); check("R6 status", d, 32'h005B_0002);
  endtask

  task automatic t_all();
    logic [31:0] d;
    do_reset();
    for (int c = 0; c < 16; c++) wr(caddr(c), 32'h1);
    rd(16'h0070, d); check("R3 none free", d, 32'hFFFF_0010);
    wr(caddr(9), 32'h0);
    rd(16'h0070, d); check("R2 middle freed", d, 32'hFDFF_0009);
  endtask

  task automatic t_drain();
    logic [31:0] d;
    do_reset();
    wr(caddr(3), 32'h1);
    ch_busy[3] = 1'b1;
    burst_start[3] = 1'b1; cyc(1); burst_start[3] = 1'b0;
    wr(caddr(3), 32'h0);
    rd(caddr(3), d); check("R5 held after stop", d, 32'h1);
    check("R7 run dropped", {16'h0, ch_run}, 32'h0);
    rd(16'h0070, d); check("R5 status held", d, 32'h0008_0000);
    cyc(5);
    rd(caddr(3), d); check("R5 held while busy", d, 32'h1);
    ch_busy[3] = 1'b0;
    cyc(2);
    rd(caddr(3), d); check("R10 held while outstanding", d, 32'h1);
    burst_done[3] = 1'b1; cyc(1); burst_done[3] = 1'b0;
    rd(caddr(3), d); check("R10 held on done edge", d, 32'h1);
    cyc(1);
    rd(caddr(3), d); check("R10 cleared", d, 32'h0);
    rd(16'h0070, d); check("R5 status cleared", d, 32'h0);
    wr(caddr(7), 32'h1);
    ch_busy[7] = 1'b1;
    wr(caddr(7), 32'h0);
    cyc(3);
    rd(caddr(7), d); check("R5 busy only hold", d, 32'h1);
    ch_busy[7] = 1'b0;
    cyc(1);
    rd(caddr(7), d); check("R5 busy only clear", d, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    do_reset();
    wr(16'h1004, 32'hFFFF_FFFF);
    rd(caddr(0), d); check("R9 offset write ignored", d, 32'h0);
    rd(16'h1004, d); check("R9 offset reads 0", d, 32'h0);
    rd(16'h0074, d); check("R9 unmapped reads 0", d, 32'h0);
    wr(16'h0F00, 32'h1);
    rd(16'h0070, d); check("R9 outside window", d, 32'h0);
    wr(caddr(15), 32'h1);
    rd(16'h1F00, d); check("R9 ch15 address", d, 32'h1);
    wr(16'h0070, 32'hFFFF_FFFF);
    rd(16'h0070, d); check("R9 status not writable", d, 32'h8000_0000);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fields();
    t_enable();
    t_all();
    t_drain();
    t_addr();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule